// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block decides, for each load, whether an older store still waiting in the store queue supplies the load's bytes, and what that decision costs in cycles. It keeps up to eight stores in program order. Each store holds a 12-bit page-offset address, a log2 byte size and 64 bits of data. A load presents its page offset and size. One cycle later the block returns a verdict, the forwarded bytes when forwarding succeeds, and the latency the load will see.

The dependency test is deliberately coarse. A store is a candidate whenever it touches any 8-byte aligned chunk that the load touches. Only the 12 page-offset bits take part, so two accesses exactly 4096 bytes apart look the same. Among the candidates, the youngest store is judged. That store can forward, cause a short recovery, cause a long replay, or cause an extra-long replay when the load spans a 64-byte line. The queue is filled by a push port, drained from the oldest end by a retire port, and emptied at once by a clear port.

Top module: `ldst_fwd_unit`

## Requirements
- R1: While reset is held and after it, `res_valid` is 0 and the queue is empty: the first load after reset gets verdict 0.
- R2: Verdicts are encoded 0 = no dependence, 1 = forward, 2 = quick recovery, 3 = long replay, 4 = line-cross replay. When no held store shares an 8-byte chunk with the load, the verdict is 0, the latency is 3 and the data is 0. Whenever the verdict is not 1, the data is 0.
- R3: A load whose address equals the store address and whose size is not larger than the store's gets verdict 1 with latency 5. Its data is the store's low bytes, sized to the load and zero-extended. Sizes are 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8.
- R4: A store at an 8-byte aligned address forwards its upper half. The load must start at the store address plus half the store's width and be no larger than that half. The data is the upper half's low bytes. If the store is not 8-byte aligned, the same case gives verdict 3.
- R5: A load that shares a chunk with the store but shares no byte with it gets verdict 2 with latency 3. This holds only when the load stays inside one 8-byte chunk and the store address is greater than the load address.
- R6: A load that shares a chunk with the store but no byte, and either sits above the store or spans two chunks, gets verdict 3 with latency 12. So does a load that shares bytes with the store but cannot be forwarded.
- R7: A load that spans a 64-byte line boundary and shares at least one byte with the judged store gets verdict 4 with latency 23.
- R8: When several held stores share a chunk with the load, only the youngest of them decides the verdict and the data.
- R9: Retire removes the oldest store. Clear empties the queue and takes priority over a push in the same cycle.
- R10: The result appears in the cycle after `ld_valid`, and `res_valid` is high for exactly that cycle. A store pushed in the same cycle as a load is not seen by that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_push | input | 1 | Append a store as the youngest entry |
| st_addr | input | 12 | Store page-offset address |
| st_size | input | 2 | Store log2 byte size |
| st_data | input | 64 | Store data, byte 0 at the low end |
| st_retire | input | 1 | Remove the oldest store |
| sq_clear | input | 1 | Empty the queue |
| ld_valid | input | 1 | Look up a load this cycle |
| ld_addr | input | 12 | Load page-offset address |
| ld_size | input | 2 | Load log2 byte size |
| res_valid | output | 1 | Result of the previous cycle's load is present |
| res_verdict | output | 3 | Verdict code |
| res_data | output | 64 | Forwarded bytes, zero-extended |
| res_latency | output | 5 | Load latency in cycles |

## Verification
The properties assume that the queue is never pushed while it holds eight stores unless a retire happens in the same cycle. They also assume that retire is never asserted on an empty queue. If either happened, occupancy would no longer be in step with the verdicts. The stimulus clears the queue before each scenario and never holds more than eight stores. It retires only stores it has pushed. It drives a load only on a queue whose contents it set up itself, so every verdict it expects follows from the stores it wrote.

// File: rtl/ldst_fwd_pkg.sv
package ldst_fwd_pkg;

  typedef enum logic [2:0] {
    V_NONE  = 3'd0,
    V_FWD   = 3'd1,
    V_QUICK = 3'd2,
    V_LONG  = 3'd3,
    V_LINE  = 3'd4
  } verdict_e;

endpackage

// File: rtl/ldst_fwd_queue.sv
module ldst_fwd_queue #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12,
  parameter int SZ_W   = 2,
  parameter int DATA_W = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [ADDR_W-1:0]              push_addr,
  input  logic [SZ_W-1:0]                push_size,
  input  logic [DATA_W-1:0]              push_data,
  input  logic                           retire,
  input  logic                           clear,
  output logic [DEPTH-1:0]               ent_valid,
  output logic [DEPTH-1:0][ADDR_W-1:0]   ent_addr,
  output logic [DEPTH-1:0][SZ_W-1:0]     ent_size,
  output logic [DEPTH-1:0][DATA_W-1:0]   ent_data,
  output logic [PTR_W-1:0]               head
);

  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             retire_ok, push_ok;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic [DEPTH-1:0][SZ_W-1:0]   size_q;
  logic [DEPTH-1:0][DATA_W-1:0] data_q;

  always_comb begin
    retire_ok = retire && (cnt_q != '0);
    push_ok   = push && ((cnt_q != CNT_W'(DEPTH)) || retire_ok) && !clear;
    if (clear) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end else begin
      head_d = head_q + PTR_W'(retire_ok);
      tail_d = tail_q + PTR_W'(push_ok);
      cnt_d  = cnt_q + CNT_W'(push_ok) - CNT_W'(retire_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      addr_q[tail_q] <= push_addr;
      size_q[tail_q] <= push_size;
      data_q[tail_q] <= push_data;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_valid
    logic [PTR_W-1:0] age;
    assign age           = PTR_W'(gi) - head_q;
    assign ent_valid[gi] = ({1'b0, age} < cnt_q);
  end

  assign ent_addr = addr_q;
  assign ent_size = size_q;
  assign ent_data = data_q;
  assign head     = head_q;

endmodule

// File: rtl/ldst_fwd_cmp.sv
module ldst_fwd_cmp #(
  parameter int ADDR_W  = 12,
  parameter int SZ_W    = 2,
  parameter int CHUNK_B = 8,
  localparam int OFF_W  = $clog2(CHUNK_B),
  localparam int BYTE_W = OFF_W + 1
) (
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [SZ_W-1:0]   st_size,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SZ_W-1:0]   ld_size,
  output logic              hit,
  output logic              overlap,
  output logic              fwd_ok,
  output logic              st_above,
  output logic [OFF_W-1:0]  byte_off
);

  logic [BYTE_W-1:0] st_bytes, ld_bytes;
  logic [ADDR_W-1:0] st_last, ld_last, d_sl, d_ls;
  logic [ADDR_W-OFF_W-1:0] s0, s1, c0, c1;
  logic exact, upper;

  always_comb begin
    st_bytes = BYTE_W'(1) << st_size;
    ld_bytes = BYTE_W'(1) << ld_size;
    st_last  = st_addr + ADDR_W'(st_bytes) - ADDR_W'(1);
    ld_last  = ld_addr + ADDR_W'(ld_bytes) - ADDR_W'(1);
    s0 = st_addr[ADDR_W-1:OFF_W];
    s1 = st_last[ADDR_W-1:OFF_W];
    c0 = ld_addr[ADDR_W-1:OFF_W];
    c1 = ld_last[ADDR_W-1:OFF_W];
    hit = st_valid && ((s0 == c0) || (s0 == c1) || (s1 == c0) || (s1 == c1));
    d_sl = st_addr - ld_addr;
    d_ls = ld_addr - st_addr;
    overlap  = (d_sl < ADDR_W'(ld_bytes)) || (d_ls < ADDR_W'(st_bytes));
    exact    = (d_ls == '0) && (ld_size <= st_size);
    upper    = (st_addr[OFF_W-1:0] == '0) && (st_size != '0) &&
               (d_ls == ADDR_W'(st_bytes >> 1)) && (ld_size < st_size);
    fwd_ok   = exact || upper;
    st_above = st_addr > ld_addr;
    byte_off = d_ls[OFF_W-1:0];
  end

endmodule

// File: rtl/ldst_fwd_classify.sv
module ldst_fwd_classify
  import ldst_fwd_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int SZ_W      = 2,
  parameter int DATA_W    = 64,
  parameter int LINE_B    = 64,
  parameter int LAT_W     = 5,
  parameter int LAT_HIT   = 3,
  parameter int LAT_FWD   = 5,
  parameter int LAT_QUICK = 3,
  parameter int LAT_LONG  = 12,
  parameter int LAT_LINE  = 23,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CHUNK_B  = DATA_W / 8,
  localparam int OFF_W    = $clog2(CHUNK_B),
  localparam int LOFF_W   = $clog2(LINE_B)
) (
  input  logic [DEPTH-1:0]             hit,
  input  logic [DEPTH-1:0]             overlap,
  input  logic [DEPTH-1:0]             fwd_ok,
  input  logic [DEPTH-1:0]             st_above,
  input  logic [DEPTH-1:0][OFF_W-1:0]  byte_off,
  input  logic [DEPTH-1:0][DATA_W-1:0] ent_data,
  input  logic [PTR_W-1:0]             head,
  input  logic [LOFF_W-1:0]            ld_off,
  input  logic [SZ_W-1:0]              ld_size,
  output verdict_e                     verdict,
  output logic [DATA_W-1:0]            data,
  output logic [LAT_W-1:0]             latency
);

  logic [PTR_W-1:0]   sel, idx;
  logic               any;
  logic [OFF_W:0]     ld_bytes, chunk_sum;
  logic [LOFF_W:0]    line_sum;
  logic               cross_line, cross_chunk;
  logic [DATA_W-1:0]  shifted, mask;

  always_comb begin
    sel = '0;
    any = 1'b0;
    idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PTR_W'(k);
      if (hit[idx]) begin
        sel = idx;
        any = 1'b1;
      end
    end

    ld_bytes    = (OFF_W+1)'(1) << ld_size;
    chunk_sum   = {1'b0, ld_off[OFF_W-1:0]} + ld_bytes;
    line_sum    = {1'b0, ld_off} + (LOFF_W+1)'(ld_bytes);
    cross_chunk = chunk_sum > (OFF_W+1)'(CHUNK_B);
    cross_line  = line_sum > (LOFF_W+1)'(LINE_B);

    if (!any)                                           verdict = V_NONE;
    else if (overlap[sel] && cross_line)                verdict = V_LINE;
    else if (fwd_ok[sel])                               verdict = V_FWD;
    else if (!overlap[sel] && !cross_chunk && st_above[sel]) verdict = V_QUICK;
    else                                                verdict = V_LONG;

    shifted = ent_data[sel] >> {byte_off[sel], 3'b000};
    if (ld_size == SZ_W'(OFF_W)) mask = '1;
    else                         mask = (DATA_W'(1) << {ld_bytes, 3'b000}) - DATA_W'(1);
    data = (verdict == V_FWD) ? (shifted & mask) : '0;

    case (verdict)
      V_FWD:   latency = LAT_W'(LAT_FWD);
      V_QUICK: latency = LAT_W'(LAT_QUICK);
      V_LONG:  latency = LAT_W'(LAT_LONG);
      V_LINE:  latency = LAT_W'(LAT_LINE);
      default: latency = LAT_W'(LAT_HIT);
    endcase
  end

endmodule

// File: rtl/ldst_fwd_unit.sv
module ldst_fwd_unit
  import ldst_fwd_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 64,
  parameter int LINE_B    = 64,
  parameter int LAT_W     = 5,
  parameter int LAT_HIT   = 3,
  parameter int LAT_FWD   = 5,
  parameter int LAT_QUICK = 3,
  parameter int LAT_LONG  = 12,
  parameter int LAT_LINE  = 23,
  localparam int CHUNK_B  = DATA_W / 8,
  localparam int OFF_W    = $clog2(CHUNK_B),
  localparam int SZ_W     = $clog2(OFF_W + 1),
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int LOFF_W   = $clog2(LINE_B)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_push,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [SZ_W-1:0]   st_size,
  input  logic [DATA_W-1:0] st_data,
  input  logic              st_retire,
  input  logic              sq_clear,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SZ_W-1:0]   ld_size,
  output logic              res_valid,
  output logic [2:0]        res_verdict,
  output logic [DATA_W-1:0] res_data,
  output logic [LAT_W-1:0]  res_latency
);

  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  logic [DEPTH-1:0]             ent_valid;
  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0][SZ_W-1:0]   ent_size;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;
  logic [PTR_W-1:0]             head;

  ldst_fwd_queue #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .SZ_W(SZ_W), .DATA_W(DATA_W)
  ) i_queue (
    .clk(clk), .rst_n(rst_q_n),
    .push(st_push), .push_addr(st_addr), .push_size(st_size), .push_data(st_data),
    .retire(st_retire), .clear(sq_clear),
    .ent_valid(ent_valid), .ent_addr(ent_addr), .ent_size(ent_size),
    .ent_data(ent_data), .head(head)
  );

  logic [DEPTH-1:0]            hit, overlap, fwd_ok, st_above;
  logic [DEPTH-1:0][OFF_W-1:0] byte_off;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cmp
    ldst_fwd_cmp #(
      .ADDR_W(ADDR_W), .SZ_W(SZ_W), .CHUNK_B(CHUNK_B)
    ) i_cmp (
      .st_valid(ent_valid[gi]), .st_addr(ent_addr[gi]), .st_size(ent_size[gi]),
      .ld_addr(ld_addr), .ld_size(ld_size),
      .hit(hit[gi]), .overlap(overlap[gi]), .fwd_ok(fwd_ok[gi]),
      .st_above(st_above[gi]), .byte_off(byte_off[gi])
    );
  end

  verdict_e          cls_verdict;
  logic [DATA_W-1:0] cls_data;
  logic [LAT_W-1:0]  cls_lat;

  ldst_fwd_classify #(
    .DEPTH(DEPTH), .SZ_W(SZ_W), .DATA_W(DATA_W), .LINE_B(LINE_B), .LAT_W(LAT_W),
    .LAT_HIT(LAT_HIT), .LAT_FWD(LAT_FWD), .LAT_QUICK(LAT_QUICK),
    .LAT_LONG(LAT_LONG), .LAT_LINE(LAT_LINE)
  ) i_classify (
    .hit(hit), .overlap(overlap), .fwd_ok(fwd_ok), .st_above(st_above),
    .byte_off(byte_off), .ent_data(ent_data), .head(head),
    .ld_off(ld_addr[LOFF_W-1:0]), .ld_size(ld_size),
    .verdict(cls_verdict), .data(cls_data), .latency(cls_lat)
  );

  logic              vld_q, vld_d;
  logic [2:0]        vrd_q, vrd_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic [LAT_W-1:0]  lat_q, lat_d;

  always_comb begin
    vld_d = ld_valid;
    vrd_d = vrd_q;
    dat_d = dat_q;
    lat_d = lat_q;
    if (ld_valid) begin
      vrd_d = cls_verdict;
      dat_d = cls_data;
      lat_d = cls_lat;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q <= 1'b0;
      vrd_q <= V_NONE;
      dat_q <= '0;
      lat_q <= LAT_W'(LAT_HIT);
    end else begin
      vld_q <= vld_d;
      vrd_q <= vrd_d;
      dat_q <= dat_d;
      lat_q <= lat_d;
    end
  end

  assign res_valid   = vld_q;
  assign res_verdict = vrd_q;
  assign res_data    = dat_q;
  assign res_latency = lat_q;

endmodule

// File: rtl/ldst_fwd_unit_chk.sv
module ldst_fwd_unit_chk #(
  parameter int DATA_W    = 64,
  parameter int LAT_W     = 5,
  parameter int LAT_HIT   = 3,
  parameter int LAT_FWD   = 5,
  parameter int LAT_QUICK = 3,
  parameter int LAT_LONG  = 12,
  parameter int LAT_LINE  = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sq_clear,
  input logic              ld_valid,
  input logic              res_valid,
  input logic [2:0]        res_verdict,
  input logic [DATA_W-1:0] res_data,
  input logic [LAT_W-1:0]  res_latency
);

  // R1: no result while reset holds
  a_r1_idle_in_reset: assert property (@(posedge clk) !rst_n |-> !res_valid);

  a_r10_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> res_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !res_valid);

  a_r2_none_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_verdict == 3'd0) |-> (res_latency == LAT_W'(LAT_HIT)));

  a_r2_data_only_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_verdict != 3'd1) |-> (res_data == '0));

  a_r3_fwd_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_verdict == 3'd1) |-> (res_latency == LAT_W'(LAT_FWD)));

  a_r5_quick_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_verdict == 3'd2) |-> (res_latency == LAT_W'(LAT_QUICK)));

  a_r6_long_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_verdict == 3'd3) |-> (res_latency == LAT_W'(LAT_LONG)));

  a_r7_line_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_verdict == 3'd4) |-> (res_latency == LAT_W'(LAT_LINE)));

  a_r2_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_verdict <= 3'd4));

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_clear ##1 ld_valid) |=> (res_verdict == 3'd0));

endmodule

bind ldst_fwd_unit ldst_fwd_unit_chk #(
  .DATA_W(DATA_W), .LAT_W(LAT_W), .LAT_HIT(LAT_HIT), .LAT_FWD(LAT_FWD),
  .LAT_QUICK(LAT_QUICK), .LAT_LONG(LAT_LONG), .LAT_LINE(LAT_LINE)
) i_chk (
  .clk(clk), .rst_n(rst_q_n), .sq_clear(sq_clear), .ld_valid(ld_valid),
  .res_valid(res_valid), .res_verdict(res_verdict), .res_data(res_data),
  .res_latency(res_latency)
);

// File: tb/test_ldst_fwd_unit.sv
module test_ldst_fwd_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_push, st_retire, sq_clear, ld_valid;
  logic [11:0] st_addr, ld_addr;
  logic [1:0]  st_size, ld_size;
  logic [63:0] st_data;
  logic        res_valid;
  logic [2:0]  res_verdict;
  logic [63:0] res_data;
  logic [4:0]  res_latency;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_fwd_unit i_ldst_fwd_unit (
    .clk(clk), .rst_n(rst_n),
    .st_push(st_push), .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
    .st_retire(st_retire), .sq_clear(sq_clear),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size),
    .res_valid(res_valid), .res_verdict(res_verdict),
    .res_data(res_data), .res_latency(res_latency)
  );

  task automatic check_res(input string req, input logic [2:0] v,
                           input logic [4:0] lat, input logic [63:0] d);
    n_checks++;
    if (res_valid !== 1'b1 || res_verdict !== v || res_latency !== lat || res_data !== d) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b verdict=%0d lat=%0d data=%h, expected valid=1 verdict=%0d lat=%0d data=%h",
               req, res_valid, res_verdict, res_latency, res_data, v, lat, d);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b, expected %0b", req, act, exp);
    end
  endtask

  task automatic push_st(input logic [11:0] a, input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    st_push = 1'b1; st_addr = a; st_size = s; st_data = d;
    @(negedge clk);
    st_push = 1'b0;
  endtask

  task automatic do_load(input logic [11:0] a, input logic [1:0] s);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_size = s;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic clear_q();
    @(negedge clk);
    sq_clear = 1'b1;
    @(negedge clk);
    sq_clear = 1'b0;
  endtask

  task automatic retire_one();
    @(negedge clk);
    st_retire = 1'b1;
    @(negedge clk);
    st_retire = 1'b0;
  endtask

  task automatic t_reset();
    check_bit("R1 valid low after reset", res_valid, 1'b0);
    do_load(12'h100, 2'd3);
    check_res("R1 empty queue after reset", 3'd0, 5'd3, 64'h0);
  endtask

  task automatic t_no_match();
    clear_q();
    push_st(12'h100, 2'd3, 64'h1122334455667788);
    do_load(12'h208, 2'd1);
    check_res("R2 other chunk", 3'd0, 5'd3, 64'h0);
    do_load(12'h0F8, 2'd3);
    check_res("R2 neighbour chunk below", 3'd0, 5'd3, 64'h0);
  endtask

  task automatic t_exact();
    clear_q();
    push_st(12'h100, 2'd3, 64'h1122334455667788);
    do_load(12'h100, 2'd2);
    check_res("R3 exact narrower", 3'd1, 5'd5, 64'h55667788);
    do_load(12'h100, 2'd3);
    check_res("R3 exact full", 3'd1, 5'd5, 64'h1122334455667788);
    do_load(12'h100, 2'd0);
    check_res("R3 exact byte", 3'd1, 5'd5, 64'h88);
  endtask

  task automatic t_upper();
    clear_q();
    push_st(12'h100, 2'd3, 64'h1122334455667788);
    do_load(12'h104, 2'd2);
    check_res("R4 upper half of 8B", 3'd1, 5'd5, 64'h11223344);
    clear_q();
    push_st(12'h108, 2'd2, 64'hAABBCCDD);
    do_load(12'h10A, 2'd1);
    check_res("R4 upper half of aligned 4B", 3'd1, 5'd5, 64'hAABB);
    clear_q();
    push_st(12'h102, 2'd2, 64'hAABBCCDD);
    do_load(12'h104, 2'd1);
    check_res("R4 unaligned store no forward", 3'd3, 5'd12, 64'h0);
  endtask

  task automatic t_quick();
    clear_q();
    push_st(12'h105, 2'd0, 64'h5A);
    do_load(12'h100, 2'd2);
    check_res("R5 false dep store above", 3'd2, 5'd3, 64'h0);
  endtask

  task automatic t_long();
    clear_q();
    push_st(12'h100, 2'd1, 64'h1234);
    do_load(12'h104, 2'd2);
    check_res("R6 false dep load above", 3'd3, 5'd12, 64'h0);
    clear_q();
    push_st(12'h10A, 2'd0, 64'h77);
    do_load(12'h106, 2'd2);
    check_res("R6 false dep load spans chunks", 3'd3, 5'd12, 64'h0);
    clear_q();
    push_st(12'h100, 2'd2, 64'hDEADBEEF);
    do_load(12'h102, 2'd2);
    check_res("R6 partial overlap", 3'd3, 5'd12, 64'h0);
    clear_q();
    push_st(12'h100, 2'd1, 64'hBEEF);
    do_load(12'h100, 2'd2);
    check_res("R6 load wider than store", 3'd3, 5'd12, 64'h0);
  endtask

  task automatic t_line();
    clear_q();
    push_st(12'h13E, 2'd1, 64'h4321);
    do_load(12'h13C, 2'd3);
    check_res("R7 line cross overlap low", 3'd4, 5'd23, 64'h0);
    clear_q();
    push_st(12'h140, 2'd2, 64'h01020304);
    do_load(12'h13E, 2'd2);
    check_res("R7 line cross overlap high", 3'd4, 5'd23, 64'h0);
    clear_q();
    push_st(12'h144, 2'd0, 64'h99);
    do_load(12'h13C, 2'd3);
    check_res("R7 line cross no overlap", 3'd3, 5'd12, 64'h0);
  endtask

  task automatic t_youngest();
    clear_q();
    push_st(12'h200, 2'd3, 64'h0101010101010101);
    push_st(12'h200, 2'd3, 64'hCAFEF00D12345678);
    do_load(12'h200, 2'd2);
    check_res("R8 youngest of two exact", 3'd1, 5'd5, 64'h12345678);
    push_st(12'h204, 2'd0, 64'hEE);
    push_st(12'h500, 2'd3, 64'h5555);
    do_load(12'h200, 2'd2);
    check_res("R8 youngest matching decides", 3'd2, 5'd3, 64'h0);
  endtask

  task automatic t_retire_clear();
    clear_q();
    push_st(12'h300, 2'd3, 64'hA5A5A5A5A5A5A5A5);
    push_st(12'h380, 2'd2, 64'h99887766);
    retire_one();
    do_load(12'h300, 2'd3);
    check_res("R9 retired oldest gone", 3'd0, 5'd3, 64'h0);
    do_load(12'h380, 2'd2);
    check_res("R9 younger kept", 3'd1, 5'd5, 64'h99887766);
    clear_q();
    do_load(12'h380, 2'd2);
    check_res("R9 clear empties", 3'd0, 5'd3, 64'h0);
    @(negedge clk);
    sq_clear = 1'b1; st_push = 1'b1; st_addr = 12'h400; st_size = 2'd3; st_data = 64'h1;
    @(negedge clk);
    sq_clear = 1'b0; st_push = 1'b0;
    do_load(12'h400, 2'd3);
    check_res("R9 clear beats push", 3'd0, 5'd3, 64'h0);
    clear_q();
    for (int i = 0; i < 8; i++) push_st(12'h600 + 12'(8*i), 2'd3, 64'(i + 1));
    do_load(12'h600, 2'd3);
    check_res("R9 eight held oldest kept", 3'd1, 5'd5, 64'h1);
    do_load(12'h638, 2'd3);
    check_res("R9 eight held youngest", 3'd1, 5'd5, 64'h8);
  endtask

  task automatic t_timing();
    clear_q();
    @(negedge clk);
    st_push = 1'b1; st_addr = 12'h700; st_size = 2'd3; st_data = 64'h0F0F;
    ld_valid = 1'b1; ld_addr = 12'h700; ld_size = 2'd3;
    @(negedge clk);
    st_push = 1'b0; ld_valid = 1'b0;
    check_res("R10 same-cycle store unseen", 3'd0, 5'd3, 64'h0);
    @(negedge clk);
    check_bit("R10 valid one cycle only", res_valid, 1'b0);
    do_load(12'h700, 2'd3);
    check_res("R10 store seen next cycle", 3'd1, 5'd5, 64'h0F0F);
  endtask

  initial begin
    rst_n = 1'b0;
    st_push = 1'b0; st_retire = 1'b0; sq_clear = 1'b0; ld_valid = 1'b0;
    st_addr = '0; st_size = '0; st_data = '0; ld_addr = '0; ld_size = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_no_match();
    t_exact();
    t_upper();
    t_quick();
    t_long();
    t_line();
    t_youngest();
    t_retire_clear();
    t_timing();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule